// File: doc/BRIEF.md
# Click-free volume ramp sequencer

This block is a host-side controller for an audio front end that takes a 16-bit control word over a three-wire serial bus made of a select line, a clock and a data line. The 5-bit volume field of that word sits at bits 15:11. When the block is asked for a new volume, it does not jump there. It walks the field one code per frame from the current value to the requested value. Every frame carries the full control word, and only the volume field changes from one frame to the next.

Codes 1 to 6 lie in the muted part of the attenuator and cause audible clicks, so the walk never sends them. It jumps directly between 0 and 7. Frames start a fixed number of system clock cycles apart. The serial half-period is also set in system cycles, so the bus can be kept under its clock-rate and setup/hold limits. The host pulses a start input with a target code and the present control word. It sees a busy level while the ramp runs and a done pulse when the ramp has finished.

Top module: `vol_ramp_seq`

## Requirements
- R1: While reset is high and in the cycle after it is released, bus_cs_o, bus_sck_o, bus_sdo_o, busy_o and done_o are all 0.
- R2: Each frame follows this pattern. bus_cs_o is high for exactly 33*HALF_CYC cycles. bus_sck_o gives 16 rising edges, the first one HALF_CYC cycles after bus_cs_o rises. Each high and each low phase of bus_sck_o lasts HALF_CYC cycles. bus_sdo_o carries word bit 0 first and bit 15 last, and holds steady while bus_sck_o is high. Bits 10:0 equal ctrl_word_i as captured at the accepted start, whatever ctrl_word_i does afterwards.
- R3: When the target is above the captured code (bits 15:11), each frame raises the code by one. The exception is a code below 7, which goes directly to 7. The walk stops at the target.
- R4: When the target is below the captured code, each frame lowers the code by one. The exception is a code of 7 or less, which goes directly to 0.
- R5: No frame ever carries a volume code from 1 to 6.
- R6: A target code from 1 to 6 is replaced by 7 when it lies above the captured code and by 0 when it lies below it.
- R7: Within one ramp, successive frames start exactly FRAME_CYC cycles apart. The first frame's select rises two cycles after the start pulse is sampled.
- R8: If the target equals the captured code, no frame is sent, busy_o stays 0, and done_o is high in the cycle after the start pulse.
- R9: busy_o is high from the cycle after an accepted start until done_o. done_o is a one-cycle pulse that comes one cycle after bus_cs_o falls at the end of the last frame.
- R10: A start pulse while busy_o is high has no effect. The frames sent, their count and the single done pulse are those of the ramp already running.
- R11: A ramp from 0 to 31, or from 31 to 0, sends exactly 25 frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin a ramp |
| target_i | input | VOL_W (5) | Requested volume code |
| ctrl_word_i | input | WORD_W (16) | Present control word; its volume field is the starting code |
| bus_cs_o | output | 1 | Serial frame select, high during a frame |
| bus_sck_o | output | 1 | Serial clock, data sampled on its rising edge |
| bus_sdo_o | output | 1 | Serial data, LSB first |
| busy_o | output | 1 | Ramp in progress |
| done_o | output | 1 | One-cycle pulse when the ramp is finished |

## Verification
The properties assume that the parameters keep the frame interval longer than one frame: FRAME_CYC must be at least 33*HALF_CYC plus a few cycles. Otherwise the select line would still be high when the next frame is due. They place no constraint on start_i, target_i or ctrl_word_i. The stimulus sets HALF_CYC to 2 and FRAME_CYC to 100, which meets that margin. It drives start pulses, targets and control words at any value, including starting codes inside the muted band, targets inside the band, equal codes, and starts and word changes issued in the middle of a ramp.

// File: rtl/vol_ramp_pkg.sv
package vol_ramp_pkg;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_SEND,
    RS_GAP
  } ramp_st_t;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_LOW,
    TX_HIGH,
    TX_HOLD
  } tx_st_t;

endpackage

// File: rtl/vr_step.sv
// Pure combinational stepping rules: direction, target folding out of the
// muted band, and the next code of the walk.
module vr_step #(
  parameter int VOL_W    = 5,
  parameter int SKIP_TOP = 6
) (
  input  logic [VOL_W-1:0] cur_i,
  input  logic [VOL_W-1:0] goal_i,
  output logic             dir_up_o,
  output logic [VOL_W-1:0] goal_norm_o,
  input  logic [VOL_W-1:0] walk_from_i,
  input  logic             walk_up_i,
  output logic [VOL_W-1:0] walk_next_o
);
  localparam logic [VOL_W-1:0] BAND_HI = VOL_W'(SKIP_TOP);
  localparam logic [VOL_W-1:0] JUMP    = VOL_W'(SKIP_TOP + 1);

  logic goal_in_band;

  always_comb begin
    dir_up_o     = (goal_i > cur_i);
    goal_in_band = (goal_i != '0) && (goal_i <= BAND_HI);
    if (goal_in_band)
      goal_norm_o = dir_up_o ? JUMP : '0;
    else
      goal_norm_o = goal_i;
  end

  always_comb begin
    if (walk_up_i)
      walk_next_o = (walk_from_i < JUMP) ? JUMP : walk_from_i + 1'b1;
    else
      walk_next_o = (walk_from_i <= JUMP) ? '0 : walk_from_i - 1'b1;
  end

endmodule

// File: rtl/vr_pacer.sv
// Frame-interval timer: restarted at each frame launch, flags when the
// next launch is due so that launches are FRAME_CYC cycles apart.
module vr_pacer #(
  parameter int FRAME_CYC = 31250
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic due_o
);
  localparam int CW = $clog2(FRAME_CYC);
  localparam logic [CW-1:0] LOAD = CW'(FRAME_CYC - 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (restart_i)
      cnt <= LOAD;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign due_o = (cnt == '0);

endmodule

// File: rtl/vr_shifter.sv
// Sends one word LSB first: select high, HALF_CYC low / HALF_CYC high per
// bit, HALF_CYC hold after the last bit, then a one-cycle fin pulse.
module vr_shifter
  import vol_ramp_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int HALF_CYC = 42
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              cs_o,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              fin_o
);
  localparam int PH_W = $clog2(HALF_CYC + 1);
  localparam int IX_W = $clog2(WORD_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CYC - 1);
  localparam logic [IX_W-1:0] IX_LAST = IX_W'(WORD_W - 1);

  tx_st_t            st;
  logic [PH_W-1:0]   ph;
  logic [IX_W-1:0]   idx;
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= TX_IDLE;
      ph    <= '0;
      idx   <= '0;
      sh    <= '0;
      cs_o  <= 1'b0;
      sck_o <= 1'b0;
      sdo_o <= 1'b0;
      fin_o <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      case (st)
        TX_IDLE: begin
          if (go_i) begin
            sh    <= word_i;
            sdo_o <= word_i[0];
            cs_o  <= 1'b1;
            sck_o <= 1'b0;
            idx   <= '0;
            ph    <= '0;
            st    <= TX_LOW;
          end
        end
        TX_LOW: begin
          if (ph == PH_LAST) begin
            ph    <= '0;
            sck_o <= 1'b1;
            st    <= TX_HIGH;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        TX_HIGH: begin
          if (ph == PH_LAST) begin
            ph    <= '0;
            sck_o <= 1'b0;
            if (idx == IX_LAST) begin
              st <= TX_HOLD;
            end else begin
              idx   <= idx + 1'b1;
              sh    <= sh >> 1;
              sdo_o <= sh[1];
              st    <= TX_LOW;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        TX_HOLD: begin
          if (ph == PH_LAST) begin
            ph    <= '0;
            cs_o  <= 1'b0;
            sdo_o <= 1'b0;
            fin_o <= 1'b1;
            st    <= TX_IDLE;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vol_ramp_seq.sv
module vol_ramp_seq
  import vol_ramp_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int VOL_LSB   = 11,
  parameter int VOL_W     = 5,
  parameter int SKIP_TOP  = 6,
  parameter int HALF_CYC  = 42,
  parameter int FRAME_CYC = 31250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [VOL_W-1:0]  target_i,
  input  logic [WORD_W-1:0] ctrl_word_i,
  output logic              bus_cs_o,
  output logic              bus_sck_o,
  output logic              bus_sdo_o,
  output logic              busy_o,
  output logic              done_o
);
  ramp_st_t          st;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] tx_word_q;
  logic [VOL_W-1:0]  code_q;
  logic [VOL_W-1:0]  goal_q;
  logic              up_q;
  logic              go_q;
  logic              busy_q;
  logic              done_q;

  logic [VOL_W-1:0]  in_code;
  logic              dir_up;
  logic [VOL_W-1:0]  goal_norm;
  logic [VOL_W-1:0]  walk_from;
  logic              walk_up;
  logic [VOL_W-1:0]  walk_next;
  logic [WORD_W-1:0] next_word;
  logic              due;
  logic              fin;

  assign in_code   = ctrl_word_i[VOL_LSB +: VOL_W];
  assign walk_from = (st == RS_IDLE) ? in_code : code_q;
  assign walk_up   = (st == RS_IDLE) ? dir_up  : up_q;

  always_comb begin
    next_word = (st == RS_IDLE) ? ctrl_word_i : word_q;
    next_word[VOL_LSB +: VOL_W] = walk_next;
  end

  vr_step #(
    .VOL_W    (VOL_W),
    .SKIP_TOP (SKIP_TOP)
  ) u_step (
    .cur_i       (in_code),
    .goal_i      (target_i),
    .dir_up_o    (dir_up),
    .goal_norm_o (goal_norm),
    .walk_from_i (walk_from),
    .walk_up_i   (walk_up),
    .walk_next_o (walk_next)
  );

  vr_pacer #(
    .FRAME_CYC (FRAME_CYC)
  ) u_pacer (
    .clk       (clk),
    .rst       (rst),
    .restart_i (go_q),
    .due_o     (due)
  );

  vr_shifter #(
    .WORD_W   (WORD_W),
    .HALF_CYC (HALF_CYC)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .go_i   (go_q),
    .word_i (tx_word_q),
    .cs_o   (bus_cs_o),
    .sck_o  (bus_sck_o),
    .sdo_o  (bus_sdo_o),
    .fin_o  (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RS_IDLE;
      word_q    <= '0;
      tx_word_q <= '0;
      code_q    <= '0;
      goal_q    <= '0;
      up_q      <= 1'b0;
      go_q      <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (st)
        RS_IDLE: begin
          if (start_i) begin
            word_q <= ctrl_word_i;
            if (target_i == in_code) begin
              done_q <= 1'b1;
            end else begin
              goal_q    <= goal_norm;
              up_q      <= dir_up;
              code_q    <= walk_next;
              tx_word_q <= next_word;
              go_q      <= 1'b1;
              busy_q    <= 1'b1;
              st        <= RS_SEND;
            end
          end
        end
        RS_SEND: begin
          if (fin) begin
            if (code_q == goal_q) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              st     <= RS_IDLE;
            end else begin
              st <= RS_GAP;
            end
          end
        end
        RS_GAP: begin
          if (due) begin
            code_q    <= walk_next;
            tx_word_q <= next_word;
            go_q      <= 1'b1;
            st        <= RS_SEND;
          end
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/vol_ramp_seq_chk.sv
module vol_ramp_seq_chk #(
  parameter int VOL_W    = 5,
  parameter int SKIP_TOP = 6,
  parameter int HALF_CYC = 42
) (
  input logic             clk,
  input logic             rst,
  input logic             cs,
  input logic             sck,
  input logic             sdo,
  input logic             busy,
  input logic             done,
  input logic             launch,
  input logic [VOL_W-1:0] sent_code
);
  localparam int HC_W = $clog2(HALF_CYC + 1) + 1;
  localparam logic [HC_W-1:0]  HC_FULL = HC_W'(HALF_CYC);
  localparam logic [VOL_W-1:0] BAND_HI = VOL_W'(SKIP_TOP);

  logic [HC_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      hi_cnt <= '0;
    else if (sck)
      hi_cnt <= hi_cnt + 1'b1;
    else
      hi_cnt <= '0;
  end

  a_r2_sck_in_frame: assert property (@(posedge clk) disable iff (rst)
    sck |-> cs);

  a_r2_data_steady: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(sdo));

  a_r2_high_width: assert property (@(posedge clk) disable iff (rst)
    $fell(sck) |-> (hi_cnt == HC_FULL));

  a_r5_no_band_code: assert property (@(posedge clk) disable iff (rst)
    launch |-> !((sent_code != '0) && (sent_code <= BAND_HI)));

  a_r9_frame_busy: assert property (@(posedge clk) disable iff (rst)
    cs |-> busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cs && !busy));

endmodule

bind vol_ramp_seq vol_ramp_seq_chk #(
  .VOL_W    (VOL_W),
  .SKIP_TOP (SKIP_TOP),
  .HALF_CYC (HALF_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs        (bus_cs_o),
  .sck       (bus_sck_o),
  .sdo       (bus_sdo_o),
  .busy      (busy_o),
  .done      (done_o),
  .launch    (go_q),
  .sent_code (tx_word_q[VOL_LSB +: VOL_W])
);

// File: tb/vol_ramp_seq_bench.sv
module vol_ramp_seq_bench;
  localparam int HALF  = 2;
  localparam int FRAME = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  target = '0;
  logic [15:0] ctrl = '0;
  logic        cs, sck, sdo, busy, done;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  logic [15:0] exp_q[$];
  string       cur_tag = "R2";
  int          frames_seen = 0;
  int          last_fall = 0;
  int          prev_rise = 0;
  bit          prev_rise_ok = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vol_ramp_seq #(
    .HALF_CYC  (HALF),
    .FRAME_CYC (FRAME)
  ) u_vol_ramp_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .target_i    (target),
    .ctrl_word_i (ctrl),
    .bus_cs_o    (cs),
    .bus_sck_o   (sck),
    .bus_sdo_o   (sdo),
    .busy_o      (busy),
    .done_o      (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: rebuilds each frame from the pins and compares with the queue.
  logic        p_cs = 0, p_sck = 0;
  logic [15:0] rx = '0;
  int          rx_n = 0;
  int          rise_at = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (cs && !p_cs) begin
        rise_at = cyc;
        if (prev_rise_ok)
          check(cyc - prev_rise == FRAME, "R7", "frame spacing", cyc - prev_rise, FRAME);
        prev_rise_ok = 1;
        prev_rise = cyc;
        rx_n = 0;
      end
      if (sck && !p_sck) begin
        if (rx_n == 0)
          check(cyc - rise_at == HALF, "R2", "select to first clock", cyc - rise_at, HALF);
        if (rx_n < 16) rx[rx_n] = sdo;
        rx_n++;
      end
      if (!cs && p_cs) begin
        check(rx_n == 16, "R2", "bits per frame", rx_n, 16);
        check(cyc - rise_at == 33 * HALF, "R2", "select width", cyc - rise_at, 33 * HALF);
        check(!(rx[15:11] >= 1 && rx[15:11] <= 6), "R5", "band code sent", rx[15:11], 0);
        if (exp_q.size() == 0) begin
          check(0, cur_tag, "unexpected frame", rx, 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(rx == e, cur_tag, "frame word", rx, e);
        end
        frames_seen++;
        last_fall = cyc;
      end
      if (done) check(!cs, "R9", "done during frame", cs, 0);
    end
    p_cs  = cs;
    p_sck = sck;
  end

  task automatic ramp(input logic [15:0] w, input logic [4:0] tgt,
                      input string tag, input bit disturb);
    logic [4:0] c, g;
    bit up;
    int n = 0;
    int k = 0;
    c = w[15:11];
    if (tgt != c) begin
      up = tgt > c;
      g = tgt;
      if (g >= 1 && g <= 6) g = up ? 5'd7 : 5'd0;
      while (c != g) begin
        if (up) c = (c < 7) ? 5'd7 : c + 5'd1;
        else    c = (c <= 7) ? 5'd0 : c - 5'd1;
        exp_q.push_back({c, w[10:0]});
        n++;
      end
    end
    cur_tag = tag;
    frames_seen = 0;
    prev_rise_ok = 0;
    @(negedge clk);
    ctrl = w; target = tgt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      check(done == 1'b1, "R8", "done after equal start", done, 1);
      check(busy == 1'b0, "R8", "busy on equal start", busy, 0);
      @(negedge clk);
      check(done == 1'b0, "R8", "done width", done, 0);
      repeat (FRAME) @(negedge clk);
      check(frames_seen == 0, "R8", "frames on equal start", frames_seen, 0);
      return;
    end
    check(busy == 1'b1, "R9", "busy after start", busy, 1);
    check(done == 1'b0, "R9", "early done", done, 0);
    if (disturb) begin
      repeat (FRAME + 20) @(negedge clk);
      ctrl = ~w; target = ~tgt; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
    check(done == 1'b1, "R9", "done seen", done, 1);
    check(cyc - last_fall == 1, "R9", "done delay after select fall", cyc - last_fall, 1);
    check(frames_seen == n, tag, "frame count", frames_seen, n);
    check(exp_q.size() == 0, tag, "frames missing", exp_q.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done width", done, 0);
    check(busy == 1'b0, "R9", "busy after done", busy, 0);
    repeat (2 * FRAME) @(negedge clk);
    check(frames_seen == n, disturb ? "R10" : tag, "frames after done", frames_seen, n);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({cs, sck, sdo, busy, done} == 5'b0, "R1", "outputs in reset", {cs, sck, sdo, busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({cs, sck, sdo, busy, done} == 5'b0, "R1", "outputs after reset", {cs, sck, sdo, busy, done}, 0);

    ramp({5'd0, 11'h56B}, 5'd31, "R3", 0);
    check(frames_seen == 25, "R11", "frames 0 to 31", frames_seen, 25);
    ramp({5'd31, 11'h2A5}, 5'd0, "R4", 0);
    check(frames_seen == 25, "R11", "frames 31 to 0", frames_seen, 25);
    ramp({5'd9, 11'h0F0}, 5'd3, "R6", 0);
    ramp({5'd0, 11'h7FF}, 5'd4, "R6", 0);
    ramp({5'd3, 11'h155}, 5'd10, "R3", 0);
    ramp({5'd4, 11'h001}, 5'd2, "R4", 0);
    ramp({5'd12, 11'h333}, 5'd12, "R8", 0);
    ramp({5'd20, 11'h4C4}, 5'd17, "R10", 1);
    ramp({5'd7, 11'h111}, 5'd8, "R3", 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", cyc, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule